// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station

This block holds a small pool of renamed instructions waiting to issue to a single functional unit. Each instruction arrives with two source operands. Each source is either already ready with its value, or is waiting on the tag of the instruction that will produce it. The block watches one shared result bus that carries a valid flag, a producer tag and a data value. A waiting source whose tag equals the broadcast tag takes the value from the bus and becomes ready.

Every cycle, a select stage looks at the entries whose two sources are both ready. It issues the one that has been in the station longest, no matter which slot it sits in, and frees that slot at the same clock edge. The instruction's operation code, both operand values and its destination tag go to the functional unit. A full indication stops insertion when every slot is occupied. A flush input empties the station in one cycle.

Top module: `tag_wakeup_station`

## Requirements
- R1: After reset, and in the first cycle after reset is released, `disp_valid` is 0 and `full` is 0.
- R2: An instruction inserted with both sources ready (`ins_*_rdy`=1) is presented on the dispatch outputs in the cycle after the insertion edge. The dispatch outputs carry its op, both given operand values and its destination tag.
- R3: A source inserted with `ins_*_rdy`=0 keeps its instruction from dispatching. A broadcast whose tag differs from that source's tag leaves it waiting.
- R4: A broadcast with `bc_valid`=1 and a tag equal to a waiting source's tag makes that source ready with `bc_val` as its value. The instruction dispatches in the cycle after the broadcast edge, if its other source is ready.
- R5: When a broadcast matches a waiting source of the instruction being inserted in the same cycle, the source is stored as ready with the broadcast value. The instruction dispatches in the next cycle.
- R6: When several entries are ready in the same cycle, the one inserted earliest is dispatched first, whatever its slot position. Only one entry is dispatched per cycle.
- R7: A dispatched entry is freed at the edge that ends its dispatch cycle. Every inserted instruction is dispatched exactly once.
- R8: `full` is 1 while all DEPTH slots hold an instruction. An insertion attempted while `full` is 1 is dropped and never dispatched.
- R9: A cycle with `flush`=1 empties every slot at its edge, including an insertion requested in that same cycle. Later broadcasts cause no dispatch of the flushed instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every held instruction |
| ins_valid | input | 1 | Insert request |
| ins_op | input | OP_W | Operation code of the new instruction |
| ins_a_rdy | input | 1 | Source A value is present |
| ins_a_tag | input | TAG_W | Producer tag for source A |
| ins_a_val | input | DATA_W | Source A value when ready |
| ins_b_rdy | input | 1 | Source B value is present |
| ins_b_tag | input | TAG_W | Producer tag for source B |
| ins_b_val | input | DATA_W | Source B value when ready |
| ins_dst | input | TAG_W | Destination tag of the new instruction |
| full | output | 1 | No free slot; insertion is dropped |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Value of the broadcast result |
| disp_valid | output | 1 | An instruction is issued this cycle |
| disp_op | output | OP_W | Issued operation code |
| disp_a | output | DATA_W | Issued source A value |
| disp_b | output | DATA_W | Issued source B value |
| disp_dst | output | TAG_W | Issued destination tag |

## Verification
The hardest situation to reach is one where the oldest ready entry sits in a higher slot than a younger ready entry. A lowest-index picker would pass every plain test. The stimulus first holds two waiting entries and wakes only the one in slot 0, then waits for that slot to drain. It inserts a new instruction that lands in the freed low slot. A single broadcast then wakes both entries together, and the expected issue order is the older, higher-slot one first. A second hard case fills the station with entries waiting on one tag, offers an instruction whose operands are all ready, and checks that it never issues after the whole batch drains.

// File: rtl/rs_pkg.sv
package rs_pkg;
   localparam int unsigned NUM_SRC = 2;
   typedef enum int unsigned {
      SRC_A = 0,
      SRC_B = 1
   } src_sel_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ins_rdy,
   input  logic [TAG_W-1:0]  ins_tag,
   input  logic [DATA_W-1:0] ins_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   logic [TAG_W-1:0] tag_q;
   logic             hit_new;
   logic             hit_old;

   assign hit_new = bc_valid && (bc_tag == ins_tag);
   assign hit_old = bc_valid && (bc_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         val   <= '0;
         tag_q <= '0;
      end else if (load) begin
         tag_q <= ins_tag;
         if (ins_rdy) begin
            rdy <= 1'b1;
            val <= ins_val;
         end else if (hit_new) begin
            rdy <= 1'b1;
            val <= bc_val;
         end else begin
            rdy <= 1'b0;
            val <= ins_val;
         end
      end else if (!rdy && hit_old) begin
         rdy <= 1'b1;
         val <= bc_val;
      end
   end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
   import rs_pkg::*;
#(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OP_W   = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            load,
   input  logic                            free,
   input  logic [OP_W-1:0]                 ins_op,
   input  logic [NUM_SRC-1:0]              ins_rdy,
   input  logic [NUM_SRC-1:0][TAG_W-1:0]   ins_tag,
   input  logic [NUM_SRC-1:0][DATA_W-1:0]  ins_val,
   input  logic [TAG_W-1:0]                ins_dst,
   input  logic                            bc_valid,
   input  logic [TAG_W-1:0]                bc_tag,
   input  logic [DATA_W-1:0]               bc_val,
   output logic                            vld,
   output logic [NUM_SRC-1:0]              src_rdy,
   output logic [NUM_SRC-1:0][DATA_W-1:0]  src_val,
   output logic [OP_W-1:0]                 op,
   output logic [TAG_W-1:0]                dst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= 1'b0;
         op  <= '0;
         dst <= '0;
      end else if (flush) begin
         vld <= 1'b0;
      end else if (load) begin
         vld <= 1'b1;
         op  <= ins_op;
         dst <= ins_dst;
      end else if (free) begin
         vld <= 1'b0;
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load && !flush),
         .ins_rdy  (ins_rdy[s]),
         .ins_tag  (ins_tag[s]),
         .ins_val  (ins_val[s]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_val   (bc_val),
         .rdy      (src_rdy[s]),
         .val      (src_val[s])
      );
   end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] load,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant
);
   // older_q[j][i] = 1 means slot j was filled before slot i
   logic [DEPTH-1:0][DEPTH-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (load[k]) begin
               for (int j = 0; j < DEPTH; j++) begin
                  older_q[k][j] <= 1'b0;
                  if (j != k) older_q[j][k] <= 1'b1;
               end
            end
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      logic [DEPTH-1:0] elder_req;
      always_comb begin
         for (int j = 0; j < DEPTH; j++) elder_req[j] = req[j] & older_q[j][i];
      end
      assign grant[i] = req[i] & ~(|elder_req);
   end
endmodule

// File: rtl/tag_wakeup_station.sv
module tag_wakeup_station
   import rs_pkg::*;
#(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ins_valid,
   input  logic [OP_W-1:0]   ins_op,
   input  logic              ins_a_rdy,
   input  logic [TAG_W-1:0]  ins_a_tag,
   input  logic [DATA_W-1:0] ins_a_val,
   input  logic              ins_b_rdy,
   input  logic [TAG_W-1:0]  ins_b_tag,
   input  logic [DATA_W-1:0] ins_b_val,
   input  logic [TAG_W-1:0]  ins_dst,
   output logic              full,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              disp_valid,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b,
   output logic [TAG_W-1:0]  disp_dst
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("tag_wakeup_station: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || DATA_W < 1 || OP_W < 1) begin : g_bad_width
      $error("tag_wakeup_station: widths must be nonzero");
   end

   logic [NUM_SRC-1:0]             in_rdy;
   logic [NUM_SRC-1:0][TAG_W-1:0]  in_tag;
   logic [NUM_SRC-1:0][DATA_W-1:0] in_val;

   assign in_rdy[SRC_A] = ins_a_rdy;
   assign in_rdy[SRC_B] = ins_b_rdy;
   assign in_tag[SRC_A] = ins_a_tag;
   assign in_tag[SRC_B] = ins_b_tag;
   assign in_val[SRC_A] = ins_a_val;
   assign in_val[SRC_B] = ins_b_val;

   logic [DEPTH-1:0]                            slot_vld;
   logic [DEPTH-1:0]                            slot_rdy_a;
   logic [DEPTH-1:0]                            slot_rdy_b;
   logic [DEPTH-1:0][NUM_SRC-1:0]               slot_rdy;
   logic [DEPTH-1:0][NUM_SRC-1:0][DATA_W-1:0]   slot_val;
   logic [DEPTH-1:0][OP_W-1:0]                  slot_op;
   logic [DEPTH-1:0][TAG_W-1:0]                 slot_dst;
   logic [DEPTH-1:0]                            first_free;
   logic [DEPTH-1:0]                            load;
   logic [DEPTH-1:0]                            req;
   logic [DEPTH-1:0]                            grant;
   logic                                        accept;

   assign full   = &slot_vld;
   assign accept = ins_valid && !full && !flush;

   always_comb begin
      logic found;
      found      = 1'b0;
      first_free = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!slot_vld[i] && !found) begin
            first_free[i] = 1'b1;
            found         = 1'b1;
         end
      end
   end

   assign load = first_free & {DEPTH{accept}};

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .load     (load[i]),
         .free     (grant[i]),
         .ins_op   (ins_op),
         .ins_rdy  (in_rdy),
         .ins_tag  (in_tag),
         .ins_val  (in_val),
         .ins_dst  (ins_dst),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_val   (bc_val),
         .vld      (slot_vld[i]),
         .src_rdy  (slot_rdy[i]),
         .src_val  (slot_val[i]),
         .op       (slot_op[i]),
         .dst      (slot_dst[i])
      );
      assign slot_rdy_a[i] = slot_rdy[i][SRC_A];
      assign slot_rdy_b[i] = slot_rdy[i][SRC_B];
      assign req[i]        = slot_vld[i] & (&slot_rdy[i]);
   end

   rs_age_pick #(.DEPTH(DEPTH)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .req   (req),
      .grant (grant)
   );

   always_comb begin
      disp_op  = '0;
      disp_a   = '0;
      disp_b   = '0;
      disp_dst = '0;
      for (int i = 0; i < DEPTH; i++) begin
         disp_op  |= slot_op[i]         & {OP_W{grant[i]}};
         disp_a   |= slot_val[i][SRC_A] & {DATA_W{grant[i]}};
         disp_b   |= slot_val[i][SRC_B] & {DATA_W{grant[i]}};
         disp_dst |= slot_dst[i]        & {TAG_W{grant[i]}};
      end
   end

   assign disp_valid = |grant;
endmodule

// File: rtl/tag_wakeup_station_chk.sv
module tag_wakeup_station_chk #(
   parameter int unsigned DEPTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             ins_valid,
   input logic             full,
   input logic             disp_valid,
   input logic [DEPTH-1:0] slot_vld,
   input logic [DEPTH-1:0] slot_rdy_a,
   input logic [DEPTH-1:0] slot_rdy_b,
   input logic [DEPTH-1:0] grant
);
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!disp_valid && !full));

   assert_grant_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> ($countones(grant) == 1 &&
                      (grant & ~(slot_vld & slot_rdy_a & slot_rdy_b)) == '0));

   assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (($past(slot_rdy_a & slot_vld & ~grant) & ~slot_rdy_a) == '0 &&
                  ($past(slot_rdy_b & slot_vld & ~grant) & ~slot_rdy_b) == '0));

   assert_free_on_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !ins_valid && !flush) |=>
         ($countones(slot_vld) == $countones($past(slot_vld)) - 1));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ins_valid && !flush && !disp_valid) |=> (full && $stable(slot_vld)));

   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (slot_vld == '0 && !disp_valid));
endmodule

bind tag_wakeup_station tag_wakeup_station_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .ins_valid  (ins_valid),
   .full       (full),
   .disp_valid (disp_valid),
   .slot_vld   (slot_vld),
   .slot_rdy_a (slot_rdy_a),
   .slot_rdy_b (slot_rdy_b),
   .grant      (grant)
);

// File: tb/test_tag_wakeup_station.sv
`timescale 1ns/1ps
module test_tag_wakeup_station;
   localparam int DEPTH = 4;
   localparam int TW = 4;
   localparam int DW = 16;
   localparam int OW = 4;
   localparam int IW = OW + DW + DW + TW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic ins_valid = 1'b0;
   logic [OW-1:0] ins_op = '0;
   logic ins_a_rdy = 1'b0, ins_b_rdy = 1'b0;
   logic [TW-1:0] ins_a_tag = '0, ins_b_tag = '0, ins_dst = '0;
   logic [DW-1:0] ins_a_val = '0, ins_b_val = '0;
   logic full;
   logic bc_valid = 1'b0;
   logic [TW-1:0] bc_tag = '0;
   logic [DW-1:0] bc_val = '0;
   logic disp_valid;
   logic [OW-1:0] disp_op;
   logic [DW-1:0] disp_a, disp_b;
   logic [TW-1:0] disp_dst;

   int checks = 0;
   int failures = 0;
   logic [IW-1:0] exp_q[$];
   string req_q[$];

   always #2 clk = ~clk;

   tag_wakeup_station #(.DEPTH(DEPTH), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) i_tag_wakeup_station (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ins_valid(ins_valid), .ins_op(ins_op),
      .ins_a_rdy(ins_a_rdy), .ins_a_tag(ins_a_tag), .ins_a_val(ins_a_val),
      .ins_b_rdy(ins_b_rdy), .ins_b_tag(ins_b_tag), .ins_b_val(ins_b_val),
      .ins_dst(ins_dst), .full(full),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
      .disp_b(disp_b), .disp_dst(disp_dst)
   );

   task automatic chk(input bit ok, input string r, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   task automatic expect_d(input int op, input int a, input int b, input int dst,
                           input string r);
      exp_q.push_back({op[OW-1:0], a[DW-1:0], b[DW-1:0], dst[TW-1:0]});
      req_q.push_back(r);
   endtask

   task automatic put(input int op, input bit ar, input int at, input int av,
                      input bit br, input int bt, input int bv, input int dst);
      ins_valid = 1'b1;
      ins_op    = op[OW-1:0];
      ins_a_rdy = ar; ins_a_tag = at[TW-1:0]; ins_a_val = av[DW-1:0];
      ins_b_rdy = br; ins_b_tag = bt[TW-1:0]; ins_b_val = bv[DW-1:0];
      ins_dst   = dst[TW-1:0];
   endtask

   task automatic bcast(input int t, input int v);
      bc_valid = 1'b1;
      bc_tag   = t[TW-1:0];
      bc_val   = v[DW-1:0];
   endtask

   task automatic step();
      @(negedge clk);
      ins_valid = 1'b0;
      bc_valid  = 1'b0;
      flush     = 1'b0;
   endtask

   // monitor: every issued instruction must match the oldest pending expectation
   always @(negedge clk) begin
      if (rst_n && disp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected dispatch op/dst", {disp_op, disp_dst}, 0);
         end else begin
            logic [IW-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk({disp_op, disp_a, disp_b, disp_dst} == e, r, "dispatch {op,a,b,dst}",
                {disp_op, disp_a, disp_b, disp_dst}, e);
         end
      end
   end

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(disp_valid == 1'b0, "R1", "disp_valid in reset", disp_valid, 0);
      chk(full == 1'b0, "R1", "full in reset", full, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(disp_valid == 1'b0, "R1", "disp_valid after reset", disp_valid, 0);
      chk(full == 1'b0, "R1", "full after reset", full, 0);

      // R2: ready-at-insert instruction issues next cycle
      put(1, 1, 0, 'h10, 1, 0, 'h20, 1);
      expect_d(1, 'h10, 'h20, 1, "R2");
      step();
      @(negedge clk);
      chk(disp_valid == 1'b0, "R7", "slot freed after issue", disp_valid, 0);

      // R3/R4: waiting source, mismatching then matching broadcast
      put(2, 0, 5, 0, 1, 0, 'h22, 2);
      step();
      for (int k = 0; k < 2; k++) begin
         chk(disp_valid == 1'b0, "R3", "waiting entry issued", disp_valid, 0);
         @(negedge clk);
      end
      bcast(6, 'h66);
      step();
      chk(disp_valid == 1'b0, "R3", "woken by wrong tag", disp_valid, 0);
      bcast(5, 'h55);
      expect_d(2, 'h55, 'h22, 2, "R4");
      step();
      @(negedge clk);

      // R5: broadcast in the insertion cycle
      put(3, 0, 7, 0, 1, 0, 'h33, 3);
      bcast(7, 'h77);
      expect_d(3, 'h77, 'h33, 3, "R5");
      step();
      @(negedge clk);

      // R6: older entry in a higher slot beats younger entry in slot 0
      put(4, 0, 10, 0, 1, 0, 'h44, 4);
      step();
      put(5, 0, 11, 0, 1, 0, 'h45, 5);
      step();
      bcast(10, 'h1A);
      expect_d(4, 'h1A, 'h44, 4, "R4");
      step();
      @(negedge clk);
      put(6, 1, 0, 'h60, 0, 11, 0, 6);
      step();
      bcast(11, 'h1B);
      expect_d(5, 'h1B, 'h45, 5, "R6");
      expect_d(6, 'h60, 'h1B, 6, "R6");
      step();
      @(negedge clk);
      @(negedge clk);
      chk(disp_valid == 1'b0, "R6", "extra issue after pair", disp_valid, 0);

      // R8: fill, attempt overflow insert, drain in age order
      for (int k = 0; k < DEPTH; k++) begin
         put(8 + k, 0, 12, 0, 1, 0, 'h80 + k, 8 + k);
         step();
      end
      chk(full == 1'b1, "R8", "full with all slots used", full, 1);
      put(15, 1, 0, 'hEE, 1, 0, 'hEF, 15);
      step();
      for (int k = 0; k < 2; k++) begin
         chk(full == 1'b1 && disp_valid == 1'b0, "R8", "{full,disp} after dropped insert",
             {full, disp_valid}, 2'b10);
         @(negedge clk);
      end
      bcast(12, 'hC0);
      for (int k = 0; k < DEPTH; k++) expect_d(8 + k, 'hC0, 'h80 + k, 8 + k, "R6");
      step();
      repeat (DEPTH) @(negedge clk);
      chk(full == 1'b0 && disp_valid == 1'b0, "R8", "{full,disp} after drain",
          {full, disp_valid}, 2'b00);

      // R9: flush with concurrent insert
      put(9, 0, 13, 0, 1, 0, 'h91, 9);
      step();
      put(10, 0, 13, 0, 1, 0, 'h92, 10);
      step();
      flush = 1'b1;
      put(14, 1, 0, 'hA1, 1, 0, 'hA2, 14);
      step();
      chk(full == 1'b0 && disp_valid == 1'b0, "R9", "{full,disp} after flush",
          {full, disp_valid}, 2'b00);
      bcast(13, 'hD0);
      step();
      for (int k = 0; k < 3; k++) begin
         chk(disp_valid == 1'b0, "R9", "flushed entry issued", disp_valid, 0);
         @(negedge clk);
      end
      put(2, 1, 0, 'hB1, 1, 0, 'hB2, 3);
      expect_d(2, 'hB1, 'hB2, 3, "R9");
      step();
      @(negedge clk);

      chk(exp_q.size() == 0, "R7", "instructions never issued", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule